// File: doc/BRIEF.md
# SIMT Branch Divergence Controller

This block steers one group of lanes that share a single instruction stream on a vector datapath. It holds the group's program counter and the mask of lanes that are currently live. Each retired instruction is reported through a step strobe and a two-bit operation code. Straight-line instructions advance the counter. A branch presents a per-lane taken vector with a taken target, a fall-through target and the address where both paths meet again. A barrier marks a rendezvous point.

When every live lane agrees on a branch, the whole group moves to the chosen target and no lane is parked. When live lanes disagree, the taken lanes run first. The fall-through lanes, their target, the meeting address and the mask before the split are recorded on a last-in-first-out frame stack. When the running path reaches the meeting address, the parked lanes take over at their own target. When they reach it too, the frame is dropped and the earlier mask comes back. A barrier ends the current path early in the same way. A split that finds the stack full is not recorded: the block raises a sticky overflow flag and the taken lanes carry on.

Top module: `simt_diverge_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, pc is 0, active_mask is all ones and overflow is 0.
- R2: In a cycle with step low, pc, active_mask and overflow keep their values whatever the other inputs carry.
- R3: A step with op 2'b00 (sequential) or 2'b11 (reserved, treated as sequential) sets pc to pc+1 and leaves active_mask unchanged, unless R6 or R7 applies to the new address.
- R4: A step with op 2'b01 (branch) looks only at the taken bits of live lanes (bit i of taken and of active_mask both belong to lane i). If all live lanes are taken, pc becomes taken_pc. If none is, pc becomes fall_pc. In both cases active_mask is unchanged.
- R5: A branch whose live lanes disagree sets pc to taken_pc and active_mask to active_mask AND taken. Unless the stack is full, it records a frame of {reconv_pc, fall_pc, parked lanes, mask before the split}.
- R6: When a non-splitting step moves the first path of the newest frame to that frame's meeting address, pc becomes the recorded fall target and active_mask becomes the parked lanes.
- R7: When a non-splitting step moves the second path of the newest frame to the meeting address, pc becomes the meeting address, active_mask returns to the mask before the split, and the frame is removed.
- R8: A step with op 2'b10 (barrier) acts as arrival at the newest frame's meeting address (R6 or R7) when a frame exists. With no frame it behaves like a sequential step.
- R9: Frames nest last in first out, up to DEPTH of them. Inner splits resolve before outer ones.
- R10: A split while DEPTH frames are held records nothing and sets overflow. pc and active_mask follow R5. overflow stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | One instruction of the group retires this cycle |
| op | input | 2 | 00 sequential, 01 branch, 10 barrier, 11 sequential |
| taken | input | LANES | Per-lane branch outcome, bit i for lane i |
| taken_pc | input | PC_W | Target of taken lanes |
| fall_pc | input | PC_W | Target of not-taken lanes |
| reconv_pc | input | PC_W | Address where both paths meet again |
| pc | output | PC_W | Current program counter of the group |
| active_mask | output | LANES | Live lanes, bit i for lane i |
| overflow | output | 1 | Sticky: a split found the frame stack full |

## Verification
A corrupted frame stays hidden while its path runs. It shows at the ports only on the step that reaches the meeting address or a barrier. At that step pc jumps to a wrong fall target, or active_mask brings back the wrong lane set, one cycle after the strobe. For that reason every split in the bench is followed through both arrivals. The bench sweeps all 256 taken patterns from a full mask and all inactive-lane patterns under a half mask, and unwinds a full stack frame by frame. A wrong count of frames shows up as a barrier that either jumps when it should step, or steps when it should jump.

// File: rtl/simt_pkg.sv
package simt_pkg;

    typedef enum logic [1:0] {
        OP_SEQ     = 2'b00,
        OP_BRANCH  = 2'b01,
        OP_BARRIER = 2'b10,
        OP_RSVD    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        BR_ALL_TAKEN  = 2'd0,
        BR_NONE_TAKEN = 2'd1,
        BR_SPLIT      = 2'd2
    } br_kind_e;

    function automatic br_kind_e classify(input logic all_live, input logic none_live);
        if (all_live)       return BR_ALL_TAKEN;
        else if (none_live) return BR_NONE_TAKEN;
        else                return BR_SPLIT;
    endfunction

endpackage

// File: rtl/simt_branch_eval.sv
module simt_branch_eval
    import simt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] active,
    input  logic [LANES-1:0] taken,
    output logic [LANES-1:0] live_taken,
    output br_kind_e         kind
);
    always_comb begin
        live_taken = active & taken;
        kind       = classify(live_taken == active, live_taken == '0);
    end
endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack #(
    parameter int EW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          upd,
    input  logic [EW-1:0] wdata,
    output logic [EW-1:0] top,
    output logic          empty,
    output logic          full
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic [EW-1:0] slot [DEPTH];

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (push) cnt <= cnt + CW'(1);
        else if (pop)  cnt <= cnt - CW'(1);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && cnt == CW'(i))
                slot[i] <= wdata;
            else if (upd && cnt == CW'(i + 1))
                slot[i] <= wdata;
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (cnt == CW'(i + 1)) top = slot[i];
    end

    // R10: a frame is never written past the last slot
    a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R9: only an existing frame is rewritten or removed
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst) (pop || upd) |-> !empty);
    a_r9_single_op: assert property (@(posedge clk) disable iff (rst) $onehot0({push, pop, upd}));
endmodule

// File: rtl/simt_diverge_ctrl.sv
module simt_diverge_ctrl
    import simt_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 8,
    parameter int PC_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [1:0]       op,
    input  logic [LANES-1:0] taken,
    input  logic [PC_W-1:0]  taken_pc,
    input  logic [PC_W-1:0]  fall_pc,
    input  logic [PC_W-1:0]  reconv_pc,
    output logic [PC_W-1:0]  pc,
    output logic [LANES-1:0] active_mask,
    output logic             overflow
);
    typedef struct packed {
        logic [PC_W-1:0]  reconv;
        logic [PC_W-1:0]  alt_pc;
        logic [LANES-1:0] alt_mask;
        logic [LANES-1:0] join_mask;
        logic             second;
    } frame_t;

    localparam int EW = $bits(frame_t);

    logic [PC_W-1:0]  pc_q, pc_n, cand;
    logic [LANES-1:0] mask_q, mask_n, live;
    logic             ovf_q, ovf_n;
    br_kind_e         kind;
    frame_t           tos, nfr;
    logic [EW-1:0]    tos_raw;
    logic             push, pop, upd, empty, full;
    logic             split, force_arrive, arrive;

    simt_branch_eval #(.LANES(LANES)) u_eval (
        .active     (mask_q),
        .taken      (taken),
        .live_taken (live),
        .kind       (kind)
    );

    simt_recon_stack #(.EW(EW), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .upd   (upd),
        .wdata (nfr),
        .top   (tos_raw),
        .empty (empty),
        .full  (full)
    );

    assign tos = frame_t'(tos_raw);

    always_comb begin
        pc_n         = pc_q;
        mask_n       = mask_q;
        ovf_n        = ovf_q;
        push         = 1'b0;
        pop          = 1'b0;
        upd          = 1'b0;
        nfr          = tos;
        split        = 1'b0;
        force_arrive = 1'b0;
        arrive       = 1'b0;
        cand         = pc_q + PC_W'(1);
        if (step) begin
            case (op)
                OP_BRANCH: begin
                    case (kind)
                        BR_ALL_TAKEN:  cand = taken_pc;
                        BR_NONE_TAKEN: cand = fall_pc;
                        default:       split = 1'b1;
                    endcase
                end
                OP_BARRIER: force_arrive = !empty;
                default: ;
            endcase
            if (split) begin
                pc_n   = taken_pc;
                mask_n = live;
                if (full) begin
                    ovf_n = 1'b1;
                end else begin
                    push = 1'b1;
                    nfr  = '{reconv: reconv_pc, alt_pc: fall_pc,
                             alt_mask: mask_q & ~live, join_mask: mask_q, second: 1'b0};
                end
            end else begin
                pc_n   = cand;
                arrive = !empty && (force_arrive || cand == tos.reconv);
                if (arrive) begin
                    if (!tos.second) begin
                        pc_n       = tos.alt_pc;
                        mask_n     = tos.alt_mask;
                        nfr.second = 1'b1;
                        upd        = 1'b1;
                    end else begin
                        pc_n   = tos.reconv;
                        mask_n = tos.join_mask;
                        pop    = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            mask_q <= '1;
            ovf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_n;
            mask_q <= mask_n;
            ovf_q  <= ovf_n;
        end
    end

    assign pc          = pc_q;
    assign active_mask = mask_q;
    assign overflow    = ovf_q;

    // R2: an idle cycle changes nothing
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pc) && $stable(active_mask) && $stable(overflow)));
    // R4: an agreeing branch with no frame keeps the lane set
    a_r4_uniform_keeps_mask: assert property (@(posedge clk) disable iff (rst)
        (step && op == OP_BRANCH && empty && (taken & active_mask) == active_mask)
        |=> (active_mask == $past(active_mask) && pc == $past(taken_pc)));
    // R5: a split leaves only the live taken lanes running
    a_r5_split_mask: assert property (@(posedge clk) disable iff (rst)
        (step && op == OP_BRANCH && (taken & active_mask) != '0 && (taken & active_mask) != active_mask)
        |=> (active_mask == $past(taken & active_mask) && pc == $past(taken_pc)));
    // R10: overflow is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow);
    // R5: some lane is always live
    a_r5_mask_nonzero: assert property (@(posedge clk) disable iff (rst) active_mask != '0);
endmodule

// File: tb/simt_diverge_ctrl_test.sv
module simt_diverge_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [7:0]  taken = '0;
    logic [15:0] taken_pc = '0, fall_pc = '0, reconv_pc = '0;
    logic [15:0] pc;
    logic [7:0]  active_mask;
    logic        overflow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    simt_diverge_ctrl #(.LANES(8), .DEPTH(4), .PC_W(16)) uut (
        .clk(clk), .rst(rst), .step(step), .op(op), .taken(taken),
        .taken_pc(taken_pc), .fall_pc(fall_pc), .reconv_pc(reconv_pc),
        .pc(pc), .active_mask(active_mask), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [15:0] xp, input logic [7:0] xm, input logic xo);
        n_chk++;
        if (pc !== xp || active_mask !== xm || overflow !== xo) begin
            n_fail++;
            $display("FAIL %s: pc=%h mask=%h ovf=%b expected pc=%h mask=%h ovf=%b",
                     req, pc, active_mask, overflow, xp, xm, xo);
        end
    endtask

    task automatic go(input logic [1:0] o, input logic [7:0] tk,
                      input logic [15:0] tp, input logic [15:0] fp, input logic [15:0] rc);
        @(negedge clk);
        step = 1'b1; op = o; taken = tk; taken_pc = tp; fall_pc = fp; reconv_pc = rc;
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] epc, base;
        logic [7:0]  prev;
        repeat (3) @(negedge clk);
        chk("R1 in reset", 16'h0, 8'hFF, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 16'h0, 8'hFF, 1'b0);

        // R2: inputs move but step stays low
        op = 2'b01; taken = 8'h0F; taken_pc = 16'h55; fall_pc = 16'h66; reconv_pc = 16'h1;
        repeat (3) @(negedge clk);
        chk("R2 idle", 16'h0, 8'hFF, 1'b0);

        go(2'b00, 8'h00, 0, 0, 0);
        chk("R3 seq", 16'h1, 8'hFF, 1'b0);
        go(2'b11, 8'hAA, 16'h77, 0, 0);
        chk("R3 reserved op", 16'h2, 8'hFF, 1'b0);
        epc = 16'h2;

        // R4/R5/R6/R8: every taken pattern from a full mask
        for (int t = 0; t < 256; t++) begin
            base = epc;
            go(2'b01, 8'(t), base + 16'd10, base + 16'd20, base + 16'd30);
            if (t == 255) begin
                chk("R4 all taken", base + 16'd10, 8'hFF, 1'b0);
                epc = base + 16'd10;
            end else if (t == 0) begin
                chk("R4 none taken", base + 16'd20, 8'hFF, 1'b0);
                epc = base + 16'd20;
            end else begin
                chk("R5 split", base + 16'd10, 8'(t), 1'b0);
                go(2'b01, 8'hFF, base + 16'd30, 16'h0, 16'h0);
                chk("R6 first path arrives", base + 16'd20, ~8'(t), 1'b0);
                go(2'b10, 8'h00, 0, 0, 0);
                chk("R8 barrier rejoins", base + 16'd30, 8'hFF, 1'b0);
                epc = base + 16'd30;
            end
        end

        // R4: taken bits of parked lanes have no effect
        for (int hi = 0; hi < 16; hi++) begin
            base = epc;
            go(2'b01, 8'h0F, base + 16'd10, base + 16'd20, base + 16'd40);
            chk("R5 half split", base + 16'd10, 8'h0F, 1'b0);
            go(2'b01, {4'(hi), 4'hF}, base + 16'd50, base + 16'd60, 16'h0);
            chk("R4 inactive ignored, taken", base + 16'd50, 8'h0F, 1'b0);
            go(2'b01, {4'(hi), 4'h0}, base + 16'd70, base + 16'd80, 16'h0);
            chk("R4 inactive ignored, not taken", base + 16'd80, 8'h0F, 1'b0);
            go(2'b10, 8'h00, 0, 0, 0);
            chk("R8 barrier to parked lanes", base + 16'd20, 8'hF0, 1'b0);
            go(2'b10, 8'h00, 0, 0, 0);
            chk("R8 barrier restores", base + 16'd40, 8'hFF, 1'b0);
            epc = base + 16'd40;
        end

        // R6/R7: arrival through sequential steps
        base = epc;
        go(2'b01, 8'h33, base + 16'd9, base + 16'd9, base + 16'd10);
        chk("R5 split 33", base + 16'd9, 8'h33, 1'b0);
        go(2'b00, 8'h00, 0, 0, 0);
        chk("R6 seq arrival", base + 16'd9, 8'hCC, 1'b0);
        go(2'b00, 8'h00, 0, 0, 0);
        chk("R7 seq second arrival", base + 16'd10, 8'hFF, 1'b0);
        go(2'b10, 8'h00, 0, 0, 0);
        chk("R8 barrier no frame", base + 16'd11, 8'hFF, 1'b0);
        epc = base + 16'd11;

        // R9/R10: fill the stack, overflow, unwind
        base = epc;
        for (int i = 0; i < 4; i++) begin
            go(2'b01, 8'hFF << (i + 1), base + 16'(100 * i + 1), base + 16'(100 * i + 2), base + 16'(100 * i + 3));
            chk("R9 nested split", base + 16'(100 * i + 1), 8'hFF << (i + 1), 1'b0);
        end
        go(2'b01, 8'hE0, base + 16'd900, base + 16'd901, base + 16'd902);
        chk("R10 overflow split", base + 16'd900, 8'hE0, 1'b1);
        go(2'b00, 8'h00, 0, 0, 0);
        chk("R10 sticky", base + 16'd901, 8'hE0, 1'b1);
        for (int i = 3; i >= 0; i--) begin
            prev = (i == 0) ? 8'hFF : (8'hFF << i);
            go(2'b10, 8'h00, 0, 0, 0);
            chk("R9 unwind parked", base + 16'(100 * i + 2), prev & ~(8'hFF << (i + 1)), 1'b1);
            go(2'b10, 8'h00, 0, 0, 0);
            chk("R9 unwind rejoin", base + 16'(100 * i + 3), prev, 1'b1);
        end
        go(2'b10, 8'h00, 0, 0, 0);
        chk("R10 overflowed split not recorded", base + 16'd4, 8'hFF, 1'b1);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears overflow", 16'h0, 8'hFF, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule